// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Every cycle it looks at the register addresses held in the decode, execute, memory and writeback stage registers, at the register-write enables of the two later stages, at a load flag for the instruction in execute, and at the redirect (taken branch or jump) flag from execute. From these it chooses where each execute-stage operand is taken from, and it tells the surrounding pipeline registers when to hold and when to clear.

The block is purely combinational and holds no state. It has no data stream of its own, so there is no valid/ready handshake; all pins are plain control levels that the pipeline registers and operand muxes sample on their own clock edge. A hold output of 1 means the pipeline register's enable is to be deasserted. A clear output of 1 means that register loads all zeros on its next edge.

Operand selects use this encoding: 2'b00 takes the register file value, 2'b01 takes the writeback-stage result, 2'b10 takes the memory-stage result. The value 2'b11 is never produced.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `fwd_sel_a` is 2'b10 when `ex_src_a` is nonzero, `mem_wr_en` is 1 and `ex_src_a` equals `mem_dst`.
- R2: When R1 does not apply, `fwd_sel_a` is 2'b01 when `ex_src_a` is nonzero, `wb_wr_en` is 1 and `ex_src_a` equals `wb_dst`.
- R3: When both the memory and writeback stages write the register named by `ex_src_a`, the memory stage is chosen (2'b10).
- R4: `fwd_sel_a` is 2'b00 when `ex_src_a` is 0, or when no stage with its write enable set has a matching destination.
- R5: `fwd_sel_b` follows R1 to R4 with `ex_src_b` in place of `ex_src_a`, independently of operand A.
- R6: `if_hold` and `id_hold` are both 1 exactly when `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a` or `id_src_b`.
- R7: A load whose `ex_dst` is 0, or any instruction with `ex_is_load` at 0, never sets `if_hold` or `id_hold`.
- R8: `id_clear` equals `ex_redirect`.
- R9: `ex_clear` is 1 when the R6 stall condition holds or `ex_redirect` is 1, including both at once.
- R10: All outputs follow their inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| mem_dst | input | 5 | Destination register of the instruction in memory |
| mem_wr_en | input | 1 | Instruction in memory writes the register file |
| wb_dst | input | 5 | Destination register of the instruction in writeback |
| wb_wr_en | input | 1 | Instruction in writeback writes the register file |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Bit 0 of the execute-stage result-source field; 1 marks a load |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| if_hold | output | 1 | Hold the fetch-stage register (enable low) |
| id_hold | output | 1 | Hold the decode-stage register (enable low) |
| id_clear | output | 1 | Clear the decode-stage register on the next edge |
| ex_clear | output | 1 | Clear the execute-stage register on the next edge |

## Verification
The block has no internal state, so any fault in its comparison or priority logic shows at the ports in the same cycle as the input pattern that exposes it. A reversed priority appears only when both later stages match one source, and a missing x0 qualifier appears only when a source or load destination is 0, so those patterns are driven on purpose besides the random ones. A stall or flush fault shows as a wrong hold or clear level for the cycle in which the load-use pair or the redirect is present.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source select encoding
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] mem_dst_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] wb_dst_i,
  input  logic              wb_we_i,
  output logic [1:0]        sel_o
);

  logic     src_live;
  logic     mem_hit;
  logic     wb_hit;
  fwd_sel_e sel;

  // Register x0 is hard-wired; it is never forwarded.
  assign src_live = |src_i;
  assign mem_hit  = src_live && mem_we_i && (src_i == mem_dst_i);
  assign wb_hit   = src_live && wb_we_i  && (src_i == wb_dst_i);

  // The memory stage holds the younger producer and wins.
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  assign sel_o = sel;

  always_comb begin
    // a_r1_no_illegal_sel
    a_r1_no_illegal_sel: assert (sel_o != 2'b11);
    // a_r3_mem_priority: writeback chosen only when memory stage cannot supply
    if (sel_o == 2'b01)
      a_r3_mem_priority: assert (!(mem_we_i && (mem_dst_i == src_i)));
    // a_r4_x0_never_fwd
    if (src_i == '0)
      a_r4_x0_never_fwd: assert (sel_o == 2'b00);
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] id_srcs_i,
  input  logic [ADDR_W-1:0]              ex_dst_i,
  input  logic                           ex_is_load_i,
  output logic                           stall_o
);

  logic [NUM_SRC-1:0] dep;
  logic               dst_live;

  assign dst_live = |ex_dst_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dep
    assign dep[g] = (id_srcs_i[g] == ex_dst_i);
  end

  assign stall_o = ex_is_load_i && dst_live && (|dep);

  always_comb begin
    // a_r7_no_stall_without_load
    if (!ex_is_load_i || ex_dst_i == '0)
      a_r7_no_stall_without_load: assert (!stall_o);
  end

endmodule

// File: rtl/hz_flush_ctrl.sv
module hz_flush_ctrl (
  input  logic stall_i,
  input  logic redirect_i,
  output logic if_hold_o,
  output logic id_hold_o,
  output logic id_clear_o,
  output logic ex_clear_o
);

  // Hold front stages and bubble execute on a load-use stall;
  // squash the two younger stages on a redirect.
  assign if_hold_o  = stall_i;
  assign id_hold_o  = stall_i;
  assign id_clear_o = redirect_i;
  assign ex_clear_o = stall_i | redirect_i;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] ex_src_a,
  input  logic [ADDR_W-1:0] ex_src_b,
  input  logic [ADDR_W-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic              wb_wr_en,
  input  logic [ADDR_W-1:0] id_src_a,
  input  logic [ADDR_W-1:0] id_src_b,
  input  logic [ADDR_W-1:0] ex_dst,
  input  logic              ex_is_load,
  input  logic              ex_redirect,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              if_hold,
  output logic              id_hold,
  output logic              id_clear,
  output logic              ex_clear
);

  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][ADDR_W-1:0] ex_srcs;
  logic [NUM_OPND-1:0][ADDR_W-1:0] id_srcs;
  logic [NUM_OPND-1:0][1:0]        sels;
  logic                            lu_stall;

  assign ex_srcs = {ex_src_b, ex_src_a};
  assign id_srcs = {id_src_b, id_src_a};

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_fwd_select #(.ADDR_W(ADDR_W)) u_fwd (
      .src_i     (ex_srcs[g]),
      .mem_dst_i (mem_dst),
      .mem_we_i  (mem_wr_en),
      .wb_dst_i  (wb_dst),
      .wb_we_i   (wb_wr_en),
      .sel_o     (sels[g])
    );
  end

  assign fwd_sel_a = sels[0];
  assign fwd_sel_b = sels[1];

  hz_load_use #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_OPND)) u_lu (
    .id_srcs_i    (id_srcs),
    .ex_dst_i     (ex_dst),
    .ex_is_load_i (ex_is_load),
    .stall_o      (lu_stall)
  );

  hz_flush_ctrl u_flush (
    .stall_i    (lu_stall),
    .redirect_i (ex_redirect),
    .if_hold_o  (if_hold),
    .id_hold_o  (id_hold),
    .id_clear_o (id_clear),
    .ex_clear_o (ex_clear)
  );

  always_comb begin
    // a_r6_holds_paired
    a_r6_holds_paired: assert (if_hold == id_hold);
    // a_r9_hold_bubbles_ex
    if (if_hold)
      a_r9_hold_bubbles_ex: assert (ex_clear);
    // a_r8_redirect_squash
    if (ex_redirect)
      a_r8_redirect_squash: assert (id_clear && ex_clear);
  end

endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] ex_src_a, ex_src_b, mem_dst, wb_dst, id_src_a, id_src_b, ex_dst;
  logic       mem_wr_en, wb_wr_en, ex_is_load, ex_redirect;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic       if_hold, id_hold, id_clear, ex_clear;

  int tests = 0;
  int fails = 0;

  pipe_hazard_ctrl u_dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .mem_dst(mem_dst),
    .mem_wr_en(mem_wr_en), .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_dst(ex_dst),
    .ex_is_load(ex_is_load), .ex_redirect(ex_redirect),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .if_hold(if_hold), .id_hold(id_hold),
    .id_clear(id_clear), .ex_clear(ex_clear)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: integer selector per requirement text
  function automatic int ref_sel(int src, int md, int mw, int wd, int ww);
    if (src == 0) return 0;
    if (mw != 0 && md == src) return 2;
    if (ww != 0 && wd == src) return 1;
    return 0;
  endfunction

  function automatic int ref_stall();
    int d = int'(ex_dst);
    if (ex_is_load == 1'b0 || d == 0) return 0;
    if (d == int'(id_src_a) || d == int'(id_src_b)) return 1;
    return 0;
  endfunction

  function automatic string tag_a(int e);
    if (e == 2) return (wb_wr_en && wb_dst == ex_src_a) ? "R3" : "R1";
    if (e == 1) return "R2";
    return "R4";
  endfunction

  task automatic compare_all();
    int ea = ref_sel(int'(ex_src_a), int'(mem_dst), int'(mem_wr_en), int'(wb_dst), int'(wb_wr_en));
    int eb = ref_sel(int'(ex_src_b), int'(mem_dst), int'(mem_wr_en), int'(wb_dst), int'(wb_wr_en));
    int st = ref_stall();
    int rd = int'(ex_redirect);
    check(tag_a(ea), int'(fwd_sel_a), ea);
    check("R5", int'(fwd_sel_b), eb);
    check(st ? "R6" : "R7", int'(if_hold), st);
    check(st ? "R6" : "R7", int'(id_hold), st);
    check("R8", int'(id_clear), rd);
    check("R9", int'(ex_clear), (st != 0 || rd != 0) ? 1 : 0);
  endtask

  task automatic drive(input logic [4:0] sa, sb, md, input logic mw,
                       input logic [4:0] wd, input logic ww,
                       input logic [4:0] da, db, ed, input logic ld, br);
    @(posedge clk); #1;
    ex_src_a = sa; ex_src_b = sb; mem_dst = md; mem_wr_en = mw;
    wb_dst = wd; wb_wr_en = ww; id_src_a = da; id_src_b = db;
    ex_dst = ed; ex_is_load = ld; ex_redirect = br;
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [4:0] pick();
    return ($urandom_range(3) == 0) ? 5'($urandom_range(31)) : 5'($urandom_range(3));
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Idle (reset-like) state: all zero inputs
    drive(0,0,0,0,0,0,0,0,0,0,0);
    check("R4", int'(fwd_sel_a), 0);
    // R1 memory forward on A, R5 B from writeback
    drive(5,7,5,1,7,1,0,0,0,0,0);
    check("R1", int'(fwd_sel_a), 2);
    check("R5", int'(fwd_sel_b), 1);
    // R3 double match
    drive(9,9,9,1,9,1,0,0,0,0,0);
    check("R3", int'(fwd_sel_a), 2);
    // R4 write enables low
    drive(9,9,9,0,9,0,0,0,0,0,0);
    check("R4", int'(fwd_sel_a), 0);
    // R4 x0 source with matching x0 destinations
    drive(0,0,0,1,0,1,0,0,0,0,0);
    check("R4", int'(fwd_sel_b), 0);
    // R2 memory enabled but differing
    drive(4,1,3,1,4,1,0,0,0,0,0);
    check("R2", int'(fwd_sel_a), 1);
    // R6 load-use on second decode source
    drive(0,0,0,0,0,0,2,6,6,1,0);
    check("R6", int'(if_hold), 1);
    // R7 load into x0
    drive(0,0,0,0,0,0,0,0,0,1,0);
    check("R7", int'(id_hold), 0);
    // R7 non-load with match
    drive(0,0,0,0,0,0,6,6,6,0,0);
    check("R7", int'(if_hold), 0);
    // R9 load-use plus redirect
    drive(0,0,0,0,0,0,3,0,3,1,1);
    check("R9", int'(ex_clear), 1);
    check("R8", int'(id_clear), 1);
    // R10 combinational response without a clock edge
    @(posedge clk); #1;
    ex_redirect = 1'b0; ex_is_load = 1'b0; ex_src_a = 5'd12;
    mem_dst = 5'd12; mem_wr_en = 1'b1;
    #0.5;
    check("R10", int'(fwd_sel_a), 2);
    check("R10", int'(ex_clear), 0);
    // Random patterns
    for (int i = 0; i < 3000; i++) begin
      drive(pick(), pick(), pick(), 1'($urandom_range(1)), pick(),
            1'($urandom_range(1)), pick(), pick(), pick(),
            1'($urandom_range(1)), 1'($urandom_range(3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule